// File: doc/BRIEF.md
# Segment Base-and-Bound Address Translator

This block turns a segmented logical address into a physical address. A request carries a segment number and an offset. The segment number selects one entry of a small internal table, and each entry holds the physical start address of the segment (its base) and the segment's length (its limit). If the offset falls inside the segment, the response carries base plus offset. If it does not, the response carries an invalid-address fault and no address.

Software, or a neighbouring controller, loads table entries through a single write port. Each entry has a valid flag that reset clears and any write sets. A request to an entry that was never loaded also faults. The response is registered and appears exactly one clock after the request. No request means no response.

Top module: `seg_xlate`

## Requirements
- R1: While reset (active-low `rst_n`) is held, and in the first cycle after it, `rsp_valid`, `rsp_err` and `rsp_addr` are all zero. Reset marks every table entry unloaded, so any request made before a write faults.
- R2: A request with `req_valid` high in cycle n gives `rsp_valid` high in cycle n+1. When `req_valid` is low in cycle n, `rsp_valid`, `rsp_err` and `rsp_addr` are all zero in cycle n+1.
- R3: For a loaded entry and an offset below its limit, `rsp_err` is 0 and `rsp_addr` is the 16-bit base plus the 12-bit offset. This is an arithmetic sum in 17 bits with no wrap, so base 65535 plus offset 4094 gives 69629. Two examples: base 2200 with offset 247 gives 2447, and base 6400 with offset 0 gives 6400.
- R4: An offset greater than or equal to the selected entry's limit gives `rsp_err` = 1 and `rsp_addr` = 0. For example, limit 400 with offset 439 faults, and an offset equal to the limit faults.
- R5: A request to an entry that has not been written since reset gives `rsp_err` = 1 and `rsp_addr` = 0, whatever the offset.
- R6: When `wr_en` is high at a clock edge, the entry at `wr_idx` takes `wr_base` and `wr_limit` and becomes loaded. Requests from the next cycle on see the new contents.
- R7: A request and a write to the same index in the same cycle are translated with that entry's contents from before the write.
- R8: An entry loaded with limit 0 faults for every offset, including 0 and 4095.
- R9: A write replaces both fields of its own entry and leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Entry index to write |
| wr_base | input | 16 | Physical start address for the entry |
| wr_limit | input | 12 | Segment length for the entry |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 3 | Segment number of the request |
| req_off | input | 12 | Offset within the segment |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Invalid-address fault |
| rsp_addr | output | 17 | Physical address, zero when faulted or idle |

## Verification
Two fixed tables with known answers are run first. For each segment, offsets 0, limit-1 and limit are requested. These three offsets separate a correct strict bound from a bound that is off by one in either direction, and they separate an addition from a concatenation. Further directed cases cover a write and a request to the same index in the same cycle, which separates old data from forwarded data. They also cover a limit of zero, unloaded entries and the largest base with a large offset, which exposes any truncated sum. A long stretch of seeded random traffic then mixes writes, idle cycles and requests, with offsets clustered around each limit, so that back-to-back requests and idle gaps are exercised together.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Default geometry of the translator
  parameter int DEF_SEG_COUNT = 8;
  parameter int DEF_BASE_W    = 16;
  parameter int DEF_LIM_W     = 12;
  parameter int DEF_OFF_W     = 12;

  // Outcome of one translation
  typedef enum logic [1:0] {
    XL_OK       = 2'd0,
    XL_OUTSIDE  = 2'd1,
    XL_UNMAPPED = 2'd2
  } xl_status_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_COUNT = seg_xlate_pkg::DEF_SEG_COUNT,
  parameter int BASE_W    = seg_xlate_pkg::DEF_BASE_W,
  parameter int LIM_W     = seg_xlate_pkg::DEF_LIM_W,
  localparam int IDX_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic              rd_loaded
);

  logic [BASE_W-1:0]    base_q  [SEG_COUNT];
  logic [LIM_W-1:0]     limit_q [SEG_COUNT];
  logic [SEG_COUNT-1:0] loaded_q;
  logic [SEG_COUNT-1:0] wr_sel;

  // One decoded select line per entry
  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_sel
    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= '0;
      for (int i = 0; i < SEG_COUNT; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SEG_COUNT; i++) begin
        if (wr_sel[i]) begin
          base_q[i]   <= wr_base;
          limit_q[i]  <= wr_limit;
          loaded_q[i] <= 1'b1;
        end
      end
    end
  end

  // Read sees registered contents, so a same-cycle write is not forwarded
  always_comb begin
    rd_base   = base_q[rd_idx];
    rd_limit  = limit_q[rd_idx];
    rd_loaded = loaded_q[rd_idx];
  end

  AST_WRITE_MARKS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> loaded_q[$past(wr_idx)]); // R6

  AST_WRITE_STORES_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)) &&
              (limit_q[$past(wr_idx)] == $past(wr_limit))); // R9

endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W  = seg_xlate_pkg::DEF_BASE_W,
  parameter int LIM_W   = seg_xlate_pkg::DEF_LIM_W,
  parameter int OFF_W   = seg_xlate_pkg::DEF_OFF_W,
  localparam int CMP_W  = (LIM_W > OFF_W) ? LIM_W : OFF_W,
  localparam int PHYS_W = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1
) (
  input  logic [BASE_W-1:0] seg_base,
  input  logic [LIM_W-1:0]  seg_limit,
  input  logic              seg_loaded,
  input  logic [OFF_W-1:0]  offset,
  output xl_status_e        status,
  output logic [PHYS_W-1:0] phys
);

  // Offsets 0 .. limit-1 are inside the segment
  function automatic logic offset_fits(input logic [OFF_W-1:0] off,
                                       input logic [LIM_W-1:0] lim);
    return CMP_W'(off) < CMP_W'(lim);
  endfunction

  // Widened sum, never wraps
  function automatic logic [PHYS_W-1:0] add_base(input logic [BASE_W-1:0] b,
                                                 input logic [OFF_W-1:0] off);
    return PHYS_W'(b) + PHYS_W'(off);
  endfunction

  always_comb begin
    if (!seg_loaded) begin
      status = XL_UNMAPPED;
      phys   = '0;
    end else if (!offset_fits(offset, seg_limit)) begin
      status = XL_OUTSIDE;
      phys   = '0;
    end else begin
      status = XL_OK;
      phys   = add_base(seg_base, offset);
    end
  end

endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg
  import seg_xlate_pkg::*;
#(
  parameter int PHYS_W = seg_xlate_pkg::DEF_BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  xl_status_e        status,
  input  logic [PHYS_W-1:0] phys,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [PHYS_W-1:0] rsp_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && (status != XL_OK);
      rsp_addr  <= (req_valid && (status == XL_OK)) ? phys : '0;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = seg_xlate_pkg::DEF_SEG_COUNT,
  parameter int BASE_W    = seg_xlate_pkg::DEF_BASE_W,
  parameter int LIM_W     = seg_xlate_pkg::DEF_LIM_W,
  parameter int OFF_W     = seg_xlate_pkg::DEF_OFF_W,
  localparam int IDX_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
  localparam int PHYS_W   = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [PHYS_W-1:0] rsp_addr
);

  // Named internal events for the assertions
  logic [BASE_W-1:0] ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic              ent_loaded;
  xl_status_e        xl_status;
  logic [PHYS_W-1:0] xl_phys;

  seg_table #(
    .SEG_COUNT (SEG_COUNT),
    .BASE_W    (BASE_W),
    .LIM_W     (LIM_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_base   (wr_base),
    .wr_limit  (wr_limit),
    .rd_idx    (req_seg),
    .rd_base   (ent_base),
    .rd_limit  (ent_limit),
    .rd_loaded (ent_loaded)
  );

  seg_bound_check #(
    .BASE_W (BASE_W),
    .LIM_W  (LIM_W),
    .OFF_W  (OFF_W)
  ) u_check (
    .seg_base   (ent_base),
    .seg_limit  (ent_limit),
    .seg_loaded (ent_loaded),
    .offset     (req_off),
    .status     (xl_status),
    .phys       (xl_phys)
  );

  seg_rsp_reg #(
    .PHYS_W (PHYS_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .status    (xl_status),
    .phys      (xl_phys),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_addr  (rsp_addr)
  );

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err && rsp_addr == '0)); // R2

  AST_FAULT_HIDES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_addr == '0)); // R4

  AST_OK_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xl_status == XL_OK) |-> ((OFF_W+LIM_W)'(req_off) < (OFF_W+LIM_W)'(ent_limit))); // R4

  AST_UNLOADED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ent_loaded) |=> rsp_err); // R5

  AST_ADDR_NOT_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xl_status == XL_OK) |-> (xl_phys >= PHYS_W'(ent_base))); // R3

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int SEG_COUNT = 8;
  localparam int BASE_W    = 16;
  localparam int LIM_W     = 12;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 3;
  localparam int PHYS_W    = 17;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BASE_W-1:0] wr_base;
  logic [LIM_W-1:0]  wr_limit;
  logic              req_valid;
  logic [IDX_W-1:0]  req_seg;
  logic [OFF_W-1:0]  req_off;
  logic              rsp_valid;
  logic              rsp_err;
  logic [PHYS_W-1:0] rsp_addr;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // Reference model of the table
  int  m_base [SEG_COUNT];
  int  m_lim  [SEG_COUNT];
  bit  m_ld   [SEG_COUNT];

  always #10 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_base   (wr_base),
    .wr_limit  (wr_limit),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .req_off   (req_off),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_addr  (rsp_addr)
  );

  function automatic bit fault_of(int s, int off);
    return !m_ld[s] || !(off < m_lim[s]);
  endfunction

  function automatic int addr_of(int s, int off);
    return fault_of(s, off) ? 0 : (m_base[s] + off);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: drives one cycle and checks the response
  task automatic step(bit we, int widx, int wb, int wl,
                      bit rv, int rs, int ro, string tag);
    int e_v, e_e, e_a;
    wr_en     = we;
    wr_idx    = IDX_W'(widx);
    wr_base   = BASE_W'(wb);
    wr_limit  = LIM_W'(wl);
    req_valid = rv;
    req_seg   = IDX_W'(rs);
    req_off   = OFF_W'(ro);
    e_v = rv;
    e_e = rv ? int'(fault_of(rs, ro)) : 0;
    e_a = rv ? addr_of(rs, ro) : 0;
    @(negedge clk);
    if (we) begin
      m_base[widx] = wb;
      m_lim[widx]  = wl;
      m_ld[widx]   = 1'b1;
    end
    check(tag, "rsp_valid", int'(rsp_valid), e_v);
    check(tag, "rsp_err",   int'(rsp_err),   e_e);
    check(tag, "rsp_addr",  int'(rsp_addr),  e_a);
  endtask

  task automatic load(int idx, int b, int l);
    step(1'b1, idx, b, l, 1'b0, 0, 0, "R6");
  endtask

  task automatic ask(int s, int off, string tag);
    step(1'b0, 0, 0, 0, 1'b1, s, off, tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int a_base [5] = '{6400, 4700, 1600, 5800, 3400};
    int a_lim  [5] = '{500, 1100, 1000, 600, 1300};
    int b_base [5] = '{5432, 115, 2200, 4235, 1650};
    int b_lim  [5] = '{350, 100, 780, 1100, 400};
    void'($urandom(32'd7321));
    for (int i = 0; i < SEG_COUNT; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_ld[i] = 1'b0;
    end
    rst_n = 1'b0; wr_en = 0; wr_idx = 0; wr_base = 0; wr_limit = 0;
    req_valid = 1'b1; req_seg = 0; req_off = 0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset even with a request pending
    check("R1", "rsp_valid", int'(rsp_valid), 0);
    check("R1", "rsp_err",   int'(rsp_err),   0);
    check("R1", "rsp_addr",  int'(rsp_addr),  0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid", int'(rsp_valid), 0);
    // R1 and R5: every entry unloaded after reset
    for (int s = 0; s < SEG_COUNT; s++) ask(s, 0, "R1");
    ask(3, 100, "R5");

    // First reference table: offsets 0, limit-1, limit
    for (int s = 0; s < 5; s++) load(s, a_base[s], a_lim[s]);
    for (int s = 0; s < 5; s++) begin
      ask(s, 0, "R3");
      ask(s, a_lim[s] - 1, "R3");
      ask(s, a_lim[s], "R4");
      ask(s, a_lim[s] + 1, "R4");
    end
    for (int s = 5; s < SEG_COUNT; s++) ask(s, 7, "R5");

    // R7: same-cycle write and read of seg 2 return old data (1600+247)
    step(1'b1, 2, b_base[2], b_lim[2], 1'b1, 2, 247, "R7");
    check("R7", "old-data model", addr_of(2, 247), 2447);
    // R9: the rewritten entry changed, its neighbours did not
    ask(2, 247, "R9");
    ask(1, 100, "R9");
    ask(3, 599, "R9");
    ask(2, 900, "R9");

    // Second reference table
    for (int s = 0; s < 5; s++) load(s, b_base[s], b_lim[s]);
    ask(2, 247, "R3");
    ask(4, 439, "R4");
    ask(4, 400, "R4");
    ask(4, 399, "R3");
    ask(1, 99, "R3");

    // R8: zero limit faults everywhere
    load(7, 1234, 0);
    ask(7, 0, "R8");
    ask(7, 4095, "R8");
    // R3: widest sum without wrap
    load(6, 65535, 4095);
    ask(6, 4094, "R3");
    ask(6, 4095, "R4");
    // R2: idle cycles produce nothing, back-to-back requests each answer
    step(1'b0, 0, 0, 0, 1'b0, 6, 4094, "R2");
    ask(6, 1, "R2");
    ask(0, 2, "R2");
    step(1'b1, 5, 300, 20, 1'b0, 5, 3, "R2");
    ask(5, 19, "R6");

    // Seeded random traffic with offsets clustered around limits
    for (int n = 0; n < 3000; n++) begin
      bit we, rv;
      int wi, wb, wl, rs, ro, pick;
      we = ($urandom_range(3) == 0);
      rv = ($urandom_range(3) != 0);
      wi = $urandom_range(SEG_COUNT - 1);
      wb = $urandom_range(65535);
      wl = ($urandom_range(7) == 0) ? 0 : $urandom_range(4095);
      rs = $urandom_range(SEG_COUNT - 1);
      pick = $urandom_range(3);
      if (pick == 0) ro = $urandom_range(4095);
      else begin
        ro = m_lim[rs] + $urandom_range(2) - 1;
        if (ro < 0) ro = 0;
        if (ro > 4095) ro = 4095;
      end
      step(we, wi, wb, wl, rv, rs, ro, rv ? "R3" : "R2");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule